// File: doc/BRIEF.md
# SMM Entry Interrupt Gating Controller

This block holds the interrupt and trap masking state of a processor core as it goes into and comes out of system management mode. A system management request from outside the mode starts entry. In that same clock the block saves the interrupt-enable flag, the trap flag and the debug-control word into a shadow set, and it forces all three to zero. While the core is in the mode, the non-maskable, system-management and address-wrap requests are held back. Software interrupts and exceptions still pass through unchanged. Maskable hardware interrupts stay gated by the interrupt-enable flag, so handler code can turn them back on by setting the flag.

A resume strobe ends the mode. It restores the shadowed values and lifts the blocking. A non-maskable or system-management request that is blocked during the mode is not lost. It is held in a pending bit, one per source, and is presented in the first cycle after exit. A pending system-management request therefore starts a new entry at once.

Top module: `smm_irq_gate`

## Requirements
- R1: When `in_smm_o` is 0 and `smi_req_i` is 1, or a system-management request is pending, `smi_deliver_o` is 1 in that cycle and `in_smm_o` is 1 after the next clock edge.
- R2: After the entry edge, `if_o`, `tf_o` and `dbg_o` are all 0. Any flag or debug write presented in the entry cycle is ignored.
- R3: While `in_smm_o` is 1, `nmi_deliver_o`, `smi_deliver_o` and `a20m_deliver_o` are 0. Outside the mode, `a20m_deliver_o` follows `a20m_req_i`.
- R4: `swint_deliver_o` equals `swint_i` and `exc_deliver_o` equals `exc_i` in every cycle, inside and outside the mode.
- R5: `intr_deliver_o` is `intr_req_i` AND `if_o`. Writing IF=1 inside the mode makes maskable interrupts deliverable from the next cycle.
- R6: `step_trap_en_o` equals `tf_o`. Writing TF=1 inside the mode enables single-step traps from the next cycle.
- R7: A resume strobe in the mode sets `in_smm_o` to 0 after the edge. It also restores `if_o`, `tf_o` and `dbg_o` to the values they held just before entry. A resume strobe outside the mode changes nothing.
- R8: An NMI or SMI request seen while `in_smm_o` is 1 (the resume cycle included) is latched. It then drives its deliver output high in the first cycle after exit, and is cleared after that cycle. A pending SMI re-enters the mode.
- R9: An SMI request inside the mode does not restart entry: the shadow values kept from the first entry are the ones restored.
- R10: Flag and debug writes in a cycle with no entry and no resume take effect after the edge. The resume strobe takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smi_req_i | input | 1 | System-management request |
| rsm_i | input | 1 | Resume (exit) strobe |
| nmi_req_i | input | 1 | Non-maskable interrupt request |
| a20m_req_i | input | 1 | Address-wrap mask request |
| intr_req_i | input | 1 | Maskable hardware interrupt request |
| swint_i | input | 1 | Software interrupt event |
| exc_i | input | 1 | Exception event |
| if_wr_i | input | 1 | Write strobe, interrupt-enable flag |
| if_val_i | input | 1 | Value for interrupt-enable flag |
| tf_wr_i | input | 1 | Write strobe, trap flag |
| tf_val_i | input | 1 | Value for trap flag |
| dbg_wr_i | input | 1 | Write strobe, debug-control word |
| dbg_val_i | input | DBG_W | Value for debug-control word |
| in_smm_o | output | 1 | Core is in system management mode |
| if_o | output | 1 | Current interrupt-enable flag |
| tf_o | output | 1 | Current trap flag |
| dbg_o | output | DBG_W | Current debug-control word |
| nmi_deliver_o | output | 1 | NMI delivered this cycle |
| smi_deliver_o | output | 1 | SMI accepted this cycle |
| a20m_deliver_o | output | 1 | Address-wrap mask delivered |
| intr_deliver_o | output | 1 | Maskable interrupt delivered |
| swint_deliver_o | output | 1 | Software interrupt delivered |
| exc_deliver_o | output | 1 | Exception delivered |
| step_trap_en_o | output | 1 | Single-step trap enable |

## Verification
The bench builds the block with `DBG_W` = 8. With that width, a distinctive debug pattern such as 0xA5 can be loaded, and the bench can tell it apart from the zero forced at entry and from a rejected write of 0x3C. The pending-bit count is fixed at two by the package, so the bench exercises both latches together. It leaves the mode while NMI and SMI are both pending and watches the SMI trigger an immediate second entry. The shadow set must survive that re-entry unchanged.

// File: rtl/smm_gate_pkg.sv
package smm_gate_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_SMM    = 1'b1
  } smm_mode_e;

  localparam int unsigned PEND_NMI = 0;
  localparam int unsigned PEND_SMI = 1;
  localparam int unsigned N_PEND   = 2;
endpackage

// File: rtl/smm_mode_fsm.sv
module smm_mode_fsm
  import smm_gate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_req_i,
  input  logic rsm_i,
  output logic in_smm_o,
  output logic enter_o,
  output logic leave_o
);
  smm_mode_e mode_q, mode_d;

  always_comb begin
    enter_o = (mode_q == MODE_NORMAL) && enter_req_i;
    leave_o = (mode_q == MODE_SMM) && rsm_i;
    mode_d  = mode_q;
    if (enter_o)      mode_d = MODE_SMM;
    else if (leave_o) mode_d = MODE_NORMAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_NORMAL;
    else         mode_q <= mode_d;
  end

  assign in_smm_o = (mode_q == MODE_SMM);

  assert_enter_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_o |=> in_smm_o);
  assert_leave_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leave_o |=> !in_smm_o);
  assert_no_reentry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_smm_o |-> !enter_o);
endmodule

// File: rtl/smm_flag_bank.sv
module smm_flag_bank #(
  parameter int unsigned DBG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_smm_i,
  input  logic             enter_i,
  input  logic             leave_i,
  input  logic             if_wr_i,
  input  logic             if_val_i,
  input  logic             tf_wr_i,
  input  logic             tf_val_i,
  input  logic             dbg_wr_i,
  input  logic [DBG_W-1:0] dbg_val_i,
  output logic             if_o,
  output logic             tf_o,
  output logic [DBG_W-1:0] dbg_o
);
  localparam int unsigned SH_W = DBG_W + 2;

  logic             if_q, tf_q;
  logic [DBG_W-1:0] dbg_q;
  logic [SH_W-1:0]  sh_q;
  logic             wr_ok;

  // entry and resume both outrank software writes
  assign wr_ok = !enter_i && !leave_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      if_q  <= 1'b0;
      tf_q  <= 1'b0;
      dbg_q <= '0;
      sh_q  <= '0;
    end else if (enter_i) begin
      sh_q  <= {if_q, tf_q, dbg_q};
      if_q  <= 1'b0;
      tf_q  <= 1'b0;
      dbg_q <= '0;
    end else if (leave_i) begin
      {if_q, tf_q, dbg_q} <= sh_q;
    end else if (wr_ok) begin
      if (if_wr_i)  if_q  <= if_val_i;
      if (tf_wr_i)  tf_q  <= tf_val_i;
      if (dbg_wr_i) dbg_q <= dbg_val_i;
    end
  end

  assign if_o  = if_q;
  assign tf_o  = tf_q;
  assign dbg_o = dbg_q;

  assert_clear_on_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i |=> (!if_q && !tf_q && dbg_q == '0));
  assert_restore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leave_i |=> ({if_q, tf_q, dbg_q} == $past(sh_q)));
  assert_shadow_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_smm_i |=> $stable(sh_q));
endmodule

// File: rtl/smm_pend_latch.sv
module smm_pend_latch #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_smm_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  for (genvar g = 0; g < N; g++) begin : g_src
    // set while blocked, dropped after one cycle of presentation outside
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_q[g] <= 1'b0;
      else if (!in_smm_i) pend_q[g] <= 1'b0;
      else if (req_i[g])  pend_q[g] <= 1'b1;
    end

    assert_latch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_smm_i && req_i[g]) |=> pend_q[g]);
    assert_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_smm_i |=> !pend_q[g]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/smm_irq_gate.sv
module smm_irq_gate
  import smm_gate_pkg::*;
#(
  parameter int unsigned DBG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smi_req_i,
  input  logic             rsm_i,
  input  logic             nmi_req_i,
  input  logic             a20m_req_i,
  input  logic             intr_req_i,
  input  logic             swint_i,
  input  logic             exc_i,
  input  logic             if_wr_i,
  input  logic             if_val_i,
  input  logic             tf_wr_i,
  input  logic             tf_val_i,
  input  logic             dbg_wr_i,
  input  logic [DBG_W-1:0] dbg_val_i,
  output logic             in_smm_o,
  output logic             if_o,
  output logic             tf_o,
  output logic [DBG_W-1:0] dbg_o,
  output logic             nmi_deliver_o,
  output logic             smi_deliver_o,
  output logic             a20m_deliver_o,
  output logic             intr_deliver_o,
  output logic             swint_deliver_o,
  output logic             exc_deliver_o,
  output logic             step_trap_en_o
);
  logic              in_smm, enter, leave;
  logic [N_PEND-1:0] pend, blk_req;

  assign blk_req[PEND_NMI] = nmi_req_i;
  assign blk_req[PEND_SMI] = smi_req_i;

  smm_mode_fsm i_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enter_req_i (smi_req_i | pend[PEND_SMI]),
    .rsm_i       (rsm_i),
    .in_smm_o    (in_smm),
    .enter_o     (enter),
    .leave_o     (leave)
  );

  smm_flag_bank #(.DBG_W(DBG_W)) i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_smm_i  (in_smm),
    .enter_i   (enter),
    .leave_i   (leave),
    .if_wr_i   (if_wr_i),
    .if_val_i  (if_val_i),
    .tf_wr_i   (tf_wr_i),
    .tf_val_i  (tf_val_i),
    .dbg_wr_i  (dbg_wr_i),
    .dbg_val_i (dbg_val_i),
    .if_o      (if_o),
    .tf_o      (tf_o),
    .dbg_o     (dbg_o)
  );

  smm_pend_latch #(.N(N_PEND)) i_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_smm_i (in_smm),
    .req_i    (blk_req),
    .pend_o   (pend)
  );

  assign in_smm_o        = in_smm;
  assign smi_deliver_o   = enter;
  assign nmi_deliver_o   = !in_smm && (nmi_req_i || pend[PEND_NMI]);
  assign a20m_deliver_o  = !in_smm && a20m_req_i;
  assign intr_deliver_o  = intr_req_i && if_o;
  assign swint_deliver_o = swint_i;
  assign exc_deliver_o   = exc_i;
  assign step_trap_en_o  = tf_o;

  assert_blocked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_smm_o |-> !(nmi_deliver_o || smi_deliver_o || a20m_deliver_o));
  assert_masked_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_smm_o) |-> !intr_deliver_o && !step_trap_en_o);
  assert_pend_nmi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_smm_o && nmi_req_i && rsm_i) |=> nmi_deliver_o);
endmodule

// File: tb/test_smm_irq_gate.sv
module test_smm_irq_gate;
  localparam int unsigned DBG_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smi_req, rsm, nmi_req, a20m_req, intr_req, swint, exc;
  logic if_wr, if_val, tf_wr, tf_val, dbg_wr;
  logic [DBG_W-1:0] dbg_val;
  logic in_smm, if_f, tf_f, nmi_d, smi_d, a20m_d, intr_d, swint_d, exc_d, step_en;
  logic [DBG_W-1:0] dbg_f;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  smm_irq_gate #(.DBG_W(DBG_W)) i_smm_irq_gate (
    .clk_i(clk), .rst_ni(rst_n), .smi_req_i(smi_req), .rsm_i(rsm),
    .nmi_req_i(nmi_req), .a20m_req_i(a20m_req), .intr_req_i(intr_req),
    .swint_i(swint), .exc_i(exc), .if_wr_i(if_wr), .if_val_i(if_val),
    .tf_wr_i(tf_wr), .tf_val_i(tf_val), .dbg_wr_i(dbg_wr), .dbg_val_i(dbg_val),
    .in_smm_o(in_smm), .if_o(if_f), .tf_o(tf_f), .dbg_o(dbg_f),
    .nmi_deliver_o(nmi_d), .smi_deliver_o(smi_d), .a20m_deliver_o(a20m_d),
    .intr_deliver_o(intr_d), .swint_deliver_o(swint_d), .exc_deliver_o(exc_d),
    .step_trap_en_o(step_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    smi_req = 0; rsm = 0; nmi_req = 0; a20m_req = 0; intr_req = 0;
    swint = 0; exc = 0; if_wr = 0; if_val = 0; tf_wr = 0; tf_val = 0;
    dbg_wr = 0; dbg_val = '0;
  endtask

  task automatic t_reset();
    check("R1 reset in_smm", in_smm, 0);
    check("R2 reset flags", {if_f, tf_f, dbg_f}, 0);
    @(negedge clk);
    if_wr = 1; if_val = 1; tf_wr = 1; tf_val = 1; dbg_wr = 1; dbg_val = 8'hA5;
    @(negedge clk); idle();
    check("R10 write outside", {if_f, tf_f, dbg_f}, {2'b11, 8'hA5});
    check("R6 step follows tf", step_en, 1);
  endtask

  task automatic t_entry();
    smi_req = 1; dbg_wr = 1; dbg_val = 8'h3C; if_wr = 1; if_val = 1;
    #1 check("R1 smi accepted", smi_d, 1);
    @(negedge clk); idle();
    check("R1 in_smm set", in_smm, 1);
    check("R2 flags cleared, write ignored", {if_f, tf_f, dbg_f}, 0);
    check("R6 step off", step_en, 0);
  endtask

  task automatic t_block();
    nmi_req = 1; smi_req = 1; a20m_req = 1; intr_req = 1; swint = 1; exc = 1;
    #1 check("R3 blocked in smm", {nmi_d, smi_d, a20m_d}, 0);
    check("R4 sw/exc pass", {swint_d, exc_d}, 2'b11);
    check("R5 intr masked", intr_d, 0);
    @(negedge clk); idle();
    check("R9 no reentry", {in_smm, if_f, tf_f, dbg_f}, {1'b1, 10'h0});
    #1 check("R4 sw/exc low", {swint_d, exc_d}, 0);
  endtask

  task automatic t_enable();
    if_wr = 1; if_val = 1; tf_wr = 1; tf_val = 1;
    @(negedge clk); idle();
    intr_req = 1;
    #1 check("R5 intr after IF set", intr_d, 1);
    check("R6 step after TF set", step_en, 1);
    @(negedge clk); idle();
  endtask

  task automatic t_exit();
    rsm = 1; if_wr = 1; if_val = 0;
    @(negedge clk); idle();
    check("R7 exit", in_smm, 0);
    check("R7 restored, R10 resume priority", {if_f, tf_f, dbg_f}, {2'b11, 8'hA5});
    #1 check("R8 pending nmi", nmi_d, 1);
    check("R8 pending smi", smi_d, 1);
    @(negedge clk);
    check("R8 pending smi re-enters", in_smm, 1);
    check("R2 cleared on re-entry", {if_f, tf_f, dbg_f}, 0);
    #1 check("R8 nmi pending dropped", nmi_d, 0);
    rsm = 1;
    @(negedge clk); idle();
    check("R7 second exit", {in_smm, if_f, tf_f, dbg_f}, {3'b011, 8'hA5});
    #1 check("R8 nothing pending", {nmi_d, smi_d}, 0);
  endtask

  task automatic t_outside();
    rsm = 1; a20m_req = 1; swint = 1; nmi_req = 1; intr_req = 1;
    #1 check("R3 a20m passes outside", a20m_d, 1);
    check("R4 swint outside", swint_d, 1);
    check("R3 nmi passes outside", nmi_d, 1);
    check("R5 intr with IF", intr_d, 1);
    @(negedge clk); idle();
    check("R7 resume outside ignored", {in_smm, if_f, tf_f, dbg_f}, {3'b011, 8'hA5});
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_entry();
    t_block();
    t_enable();
    t_exit();
    t_outside();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule